// File: doc/BRIEF.md
# Four-Bank SDRAM Command Timing Guard

This block sits between the command scheduler of a memory controller and the command pins of an SDRAM device. Each clock the scheduler presents one requested command, a bank number and the A10 flag. The guard decides from its record of bank state and its interval timers whether that command may go out on this clock. If it may, the guard drives the encoded chip-select, row-strobe, column-strobe and write-enable pins, together with the bank and A10 lines. If it may not, the pins show a no-operation and a refusal flag is raised, so the scheduler can retry later.

The guard keeps an open or closed state for each of four banks. It holds per-bank timers for activate-to-column, activate-to-precharge, activate-to-activate, precharge recovery and data recovery. It also holds shared timers for activate spacing between banks, refresh cycle time and the mode-register settle time, plus a record of the burst in flight. Every minimum interval is a parameter counted in clocks. A per-bank age counter raises a flag once a row has been open for the maximum allowed time, so the scheduler knows to close it. The outputs are combinational from the request and the registered state. State advances on the clock edge at which a command is accepted.

Top module: `sdram_cmd_guard`

## Requirements
- R1: An accepted command drives {cs_n,ras_n,cas_n,we_n} from the request code on `req_cmd`: 1 activate 0011, 2 read 0101, 3 write 0100, 4 precharge 0010, 5 auto refresh 0001, 6 mode register set 0000, 7 burst stop 0110. `ba` and `a10` then carry `req_bank` and `req_a10`.
- R2: Code 0 is a no-operation and is never refused. A refused command drives pins 0111 with `ba` and `a10` low and raises `refused` for that cycle. `accept` and `refused` are never high together.
- R3: An activate is accepted only if all of the following hold: the bank is closed; T_RP clocks have passed since it was precharged; T_RC clocks have passed since its previous activate; T_RRD clocks have passed since any activate; T_RC clocks have passed since the last auto refresh. An accepted activate opens the bank.
- R4: A read or write is accepted only to an open bank at least T_RCD clocks after its activate. Column commands may otherwise follow each other on every clock.
- R5: A precharge to an open bank needs T_RAS clocks since its activate and data recovery. For a write at cycle w, recovery lasts until w+BURST_LEN-1+T_RDL. For a read at cycle r, it lasts until r+BURST_LEN. A precharge to a closed bank is accepted and changes nothing. With A10 high the precharge covers all banks, ignores `req_bank`, and needs every open bank to qualify.
- R6: Auto refresh and mode register set are accepted only when every bank is closed with its T_RP elapsed, and at least T_RC clocks after the last auto refresh.
- R7: For T_MRD-1 clocks after an accepted mode register set, every command other than no-operation is refused.
- R8: A read or write with A10 high closes its bank at once. For the next BURST_LEN-1 clocks, reads, writes and burst stops are refused. The bank may be activated again T_RP clocks after its implied precharge point. For a read that point is c+BURST_LEN; for a write it is c+BURST_LEN-1+T_RDL.
- R9: A burst stop accepted while a burst without auto precharge is still running ends that burst. The burst's bank may then be precharged on the next clock.
- R10: `close_due[i]` rises once bank i has been open for RAS_MAX_CYC clocks since its activate, and falls when the bank closes.
- R11: After reset all banks are closed and all timers are clear, so an activate is accepted on the first clock. While reset is held, `accept` and `refused` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_cmd | input | 3 | Requested command code (R1) |
| req_bank | input | 2 | Requested bank |
| req_a10 | input | 1 | A10: auto precharge on column commands, all banks on precharge |
| accept | output | 1 | Request is legal and is being issued this clock |
| refused | output | 1 | Request is illegal this clock |
| cs_n | output | 1 | Chip select pin |
| ras_n | output | 1 | Row strobe pin |
| cas_n | output | 1 | Column strobe pin |
| we_n | output | 1 | Write enable pin |
| ba | output | 2 | Bank address pins |
| a10 | output | 1 | A10 pin |
| bank_open | output | 4 | Open state of each bank |
| close_due | output | 4 | Bank open for the maximum row time |

## Verification
The states hardest to reach from the ports are the ones a random scheduler almost never leaves in place long enough. One is a row held open until the maximum-time flag rises. The other is a burst stop that lands inside a running burst and shortens the wait before precharge. The bench reaches both with a directed script. It holds one bank open with no-operations for the whole limit, which is shrunk through the parameter. It also issues a burst stop on the clock right after a read, then a precharge two clocks before the unshortened recovery would have allowed it. After that, a long weighted random run compares every clock against a timestamp model.

// File: rtl/sdram_cmd_guard.sv
module sdram_cmd_guard #(
  parameter int T_RCD       = 3,
  parameter int T_RP        = 3,
  parameter int T_RAS       = 7,
  parameter int T_RC        = 10,
  parameter int T_RRD       = 2,
  parameter int T_RDL       = 2,
  parameter int T_MRD       = 2,
  parameter int BURST_LEN   = 4,
  parameter int RAS_MAX_CYC = 18300
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] req_cmd,
  input  logic [1:0] req_bank,
  input  logic       req_a10,
  output logic       accept,
  output logic       refused,
  output logic       cs_n,
  output logic       ras_n,
  output logic       cas_n,
  output logic       we_n,
  output logic [1:0] ba,
  output logic       a10,
  output logic [3:0] bank_open,
  output logic [3:0] close_due
);
  localparam int NB = 4;
  localparam int TW = $clog2(T_RC + T_RAS + BURST_LEN + T_RDL + T_RP + 2);
  localparam int AW = $clog2(RAS_MAX_CYC + 1);

  localparam logic [2:0] C_NOP = 3'd0, C_ACT = 3'd1, C_RD  = 3'd2, C_WR  = 3'd3,
                         C_PRE = 3'd4, C_REF = 3'd5, C_MRS = 3'd6, C_BST = 3'd7;

  localparam logic [TW-1:0] LD_RCD   = TW'(T_RCD - 1);
  localparam logic [TW-1:0] LD_RP    = TW'(T_RP - 1);
  localparam logic [TW-1:0] LD_RAS   = TW'(T_RAS - 1);
  localparam logic [TW-1:0] LD_RC    = TW'(T_RC - 1);
  localparam logic [TW-1:0] LD_RRD   = TW'(T_RRD - 1);
  localparam logic [TW-1:0] LD_MRD   = TW'(T_MRD - 1);
  localparam logic [TW-1:0] LD_BURST = TW'(BURST_LEN - 1);
  localparam logic [TW-1:0] LD_RDREC = TW'(BURST_LEN - 1);
  localparam logic [TW-1:0] LD_WRREC = TW'(BURST_LEN + T_RDL - 2);
  localparam logic [TW-1:0] LD_APRD  = TW'(BURST_LEN + T_RP - 1);
  localparam logic [TW-1:0] LD_APWR  = TW'(BURST_LEN + T_RDL + T_RP - 2);
  localparam logic [AW-1:0] AGE_MAX  = AW'(RAS_MAX_CYC);

  logic [TW-1:0] rcd_c [NB];
  logic [TW-1:0] ras_c [NB];
  logic [TW-1:0] rc_c  [NB];
  logic [TW-1:0] rp_c  [NB];
  logic [TW-1:0] dat_c [NB];
  logic [AW-1:0] age   [NB];
  logic [TW-1:0] rrd_c, ref_c, mrd_c, burst_c;
  logic          burst_ap;
  logic [1:0]    burst_bank;
  logic [NB-1:0] open_q;

  logic [NB-1:0] idle_b, pre_ok;
  logic          legal, is_col, ap_busy;
  logic [3:0]    pins;

  assign ap_busy = burst_ap && (burst_c != '0);
  assign is_col  = (req_cmd == C_RD) || (req_cmd == C_WR);

  always_comb begin
    for (int i = 0; i < NB; i++) begin
      idle_b[i]    = !open_q[i] && (rp_c[i] == '0);
      pre_ok[i]    = !open_q[i] || ((ras_c[i] == '0) && (dat_c[i] == '0));
      close_due[i] = open_q[i] && (age[i] >= AGE_MAX);
    end
  end

  always_comb begin
    legal = 1'b0;
    case (req_cmd)
      C_NOP: legal = 1'b1;
      C_ACT: legal = !open_q[req_bank] && (rp_c[req_bank] == '0) && (rc_c[req_bank] == '0)
                     && (rrd_c == '0) && (ref_c == '0);
      C_RD, C_WR: legal = open_q[req_bank] && (rcd_c[req_bank] == '0) && !ap_busy;
      C_PRE: legal = req_a10 ? (&pre_ok) : pre_ok[req_bank];
      C_REF, C_MRS: legal = (&idle_b) && (ref_c == '0);
      C_BST: legal = !ap_busy;
      default: legal = 1'b0;
    endcase
    if ((mrd_c != '0) && (req_cmd != C_NOP)) legal = 1'b0;
  end

  assign accept  = rst_n && legal && (req_cmd != C_NOP);
  assign refused = rst_n && !legal;

  always_comb begin
    pins = 4'b0111;
    if (accept) begin
      case (req_cmd)
        C_ACT:   pins = 4'b0011;
        C_RD:    pins = 4'b0101;
        C_WR:    pins = 4'b0100;
        C_PRE:   pins = 4'b0010;
        C_REF:   pins = 4'b0001;
        C_MRS:   pins = 4'b0000;
        C_BST:   pins = 4'b0110;
        default: pins = 4'b0111;
      endcase
    end
  end

  assign {cs_n, ras_n, cas_n, we_n} = pins;
  assign ba        = accept ? req_bank : 2'b00;
  assign a10       = accept ? req_a10 : 1'b0;
  assign bank_open = open_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) begin
        rcd_c[i] <= '0;
        ras_c[i] <= '0;
        rc_c[i]  <= '0;
        rp_c[i]  <= '0;
        dat_c[i] <= '0;
        age[i]   <= '0;
      end
      rrd_c      <= '0;
      ref_c      <= '0;
      mrd_c      <= '0;
      burst_c    <= '0;
      burst_ap   <= 1'b0;
      burst_bank <= 2'b00;
      open_q     <= '0;
    end else begin
      for (int i = 0; i < NB; i++) begin
        if (rcd_c[i] != '0) rcd_c[i] <= rcd_c[i] - 1'b1;
        if (ras_c[i] != '0) ras_c[i] <= ras_c[i] - 1'b1;
        if (rc_c[i]  != '0) rc_c[i]  <= rc_c[i]  - 1'b1;
        if (rp_c[i]  != '0) rp_c[i]  <= rp_c[i]  - 1'b1;
        if (dat_c[i] != '0) dat_c[i] <= dat_c[i] - 1'b1;
        if (open_q[i] && (age[i] < AGE_MAX)) age[i] <= age[i] + 1'b1;
      end
      if (rrd_c   != '0) rrd_c   <= rrd_c   - 1'b1;
      if (ref_c   != '0) ref_c   <= ref_c   - 1'b1;
      if (mrd_c   != '0) mrd_c   <= mrd_c   - 1'b1;
      if (burst_c != '0) burst_c <= burst_c - 1'b1;

      if (accept) begin
        case (req_cmd)
          C_ACT: begin
            open_q[req_bank] <= 1'b1;
            rcd_c[req_bank]  <= LD_RCD;
            ras_c[req_bank]  <= LD_RAS;
            rc_c[req_bank]   <= LD_RC;
            age[req_bank]    <= AW'(1);
            rrd_c            <= LD_RRD;
          end
          C_RD, C_WR: begin
            dat_c[req_bank] <= (req_cmd == C_WR) ? LD_WRREC : LD_RDREC;
            burst_c         <= LD_BURST;
            burst_ap        <= req_a10;
            burst_bank      <= req_bank;
            if (req_a10) begin
              open_q[req_bank] <= 1'b0;
              rp_c[req_bank]   <= (req_cmd == C_WR) ? LD_APWR : LD_APRD;
            end
          end
          C_PRE: begin
            for (int i = 0; i < NB; i++) begin
              if ((req_a10 || (req_bank == 2'(i))) && open_q[i]) begin
                open_q[i] <= 1'b0;
                rp_c[i]   <= LD_RP;
              end
            end
          end
          C_REF: ref_c <= LD_RC;
          C_MRS: mrd_c <= LD_MRD;
          C_BST: begin
            if (burst_c != '0) begin
              dat_c[burst_bank] <= '0;
              burst_c           <= '0;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/sdram_cmd_guard_chk.sv
module sdram_cmd_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] req_cmd,
  input logic [1:0] req_bank,
  input logic       req_a10,
  input logic       accept,
  input logic       refused,
  input logic       cs_n,
  input logic       ras_n,
  input logic       cas_n,
  input logic       we_n,
  input logic [1:0] ba,
  input logic       a10,
  input logic [3:0] bank_open,
  input logic [3:0] close_due
);
  a_r2_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept && refused));

  a_r2_refused_nop: assert property (@(posedge clk) disable iff (!rst_n)
    refused |-> ({cs_n, ras_n, cas_n, we_n} == 4'b0111));

  a_r3_act_on_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_cmd == 3'd1) |-> !bank_open[req_bank]);

  a_r3_act_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_cmd == 3'd1) |=> bank_open[$past(req_bank)]);

  a_r4_col_open: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (req_cmd == 3'd2 || req_cmd == 3'd3)) |-> bank_open[req_bank]);

  a_r5_pre_all_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_cmd == 3'd4 && req_a10) |=> (bank_open == 4'b0000));

  a_r6_all_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (req_cmd == 3'd5 || req_cmd == 3'd6)) |-> (bank_open == 4'b0000));

  a_r7_mrs_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_cmd == 3'd6) |=> !accept);

  a_r8_ap_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (req_cmd == 3'd2 || req_cmd == 3'd3) && req_a10) |=> !bank_open[$past(req_bank)]);

  a_r8_ap_lockout: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (req_cmd == 3'd2 || req_cmd == 3'd3) && req_a10)
      |=> !(accept && (req_cmd == 3'd2 || req_cmd == 3'd3 || req_cmd == 3'd7)));
endmodule

bind sdram_cmd_guard sdram_cmd_guard_chk u_chk (.*);

// File: tb/sdram_cmd_guard_test.sv
module sdram_cmd_guard_test;
  localparam int CLK_PERIOD = 10;
  localparam int RP = 3, RCD = 3, RAS = 7, RC = 10, RRD = 2, RDL = 2, MRD = 2, BL = 4;
  localparam int LIMIT = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] req_cmd = 3'd0;
  logic [1:0] req_bank = 2'd0;
  logic req_a10 = 1'b0;
  logic accept, refused, cs_n, ras_n, cas_n, we_n, a10;
  logic [1:0] ba;
  logic [3:0] bank_open, close_due;

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;

  bit m_open[4];
  int m_act[4], m_rp[4], m_dat[4];
  int m_last_act = -1000, m_last_ref = -1000, m_mrs = -1000, m_lock = -1000, m_bend = -1000;
  int m_bbank = 0;
  bit m_bap = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_cmd_guard #(.RAS_MAX_CYC(LIMIT)) uut (
    .clk(clk), .rst_n(rst_n), .req_cmd(req_cmd), .req_bank(req_bank), .req_a10(req_a10),
    .accept(accept), .refused(refused), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .a10(a10), .bank_open(bank_open), .close_due(close_due));

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s at cycle %0d: actual=%0d expected=%0d", tag, what, cyc, act, exp);
    end
  endtask

  function automatic logic [3:0] code(input logic [2:0] c);
    case (c)
      3'd1: return 4'b0011;
      3'd2: return 4'b0101;
      3'd3: return 4'b0100;
      3'd4: return 4'b0010;
      3'd5: return 4'b0001;
      3'd6: return 4'b0000;
      3'd7: return 4'b0110;
      default: return 4'b0111;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] c);
    if (cyc < m_mrs && c != 3'd0) return "R7";
    case (c)
      3'd1: return "R3";
      3'd2, 3'd3: return (cyc < m_lock) ? "R8" : "R4";
      3'd4: return "R5";
      3'd5, 3'd6: return "R6";
      3'd7: return (cyc < m_lock) ? "R8" : "R9";
      default: return "R2";
    endcase
  endfunction

  function automatic bit m_pre_ok(input int i);
    return !m_open[i] || (cyc >= m_act[i] + RAS && cyc >= m_dat[i]);
  endfunction

  function automatic bit m_legal(input logic [2:0] c, input int b, input bit a);
    bit ok;
    ok = 1;
    case (c)
      3'd1: ok = !m_open[b] && cyc >= m_rp[b] && cyc >= m_act[b] + RC
                 && cyc >= m_last_act + RRD && cyc >= m_last_ref + RC;
      3'd2, 3'd3: ok = m_open[b] && cyc >= m_act[b] + RCD && cyc >= m_lock;
      3'd4: begin
        if (a) begin
          for (int i = 0; i < 4; i++) if (!m_pre_ok(i)) ok = 0;
        end else ok = m_pre_ok(b);
      end
      3'd5, 3'd6: begin
        for (int i = 0; i < 4; i++) if (m_open[i] || cyc < m_rp[i]) ok = 0;
        if (cyc < m_last_ref + RC) ok = 0;
      end
      3'd7: ok = cyc >= m_lock;
      default: ok = 1;
    endcase
    if (c != 3'd0 && cyc < m_mrs) ok = 0;
    return ok;
  endfunction

  task automatic m_apply(input logic [2:0] c, input int b, input bit a);
    int rec;
    case (c)
      3'd1: begin m_open[b] = 1; m_act[b] = cyc; m_last_act = cyc; end
      3'd2, 3'd3: begin
        rec = (c == 3'd3) ? BL - 1 + RDL : BL;
        m_dat[b] = cyc + rec;
        m_bend = cyc + BL; m_bbank = b; m_bap = a;
        if (a) begin m_open[b] = 0; m_rp[b] = cyc + rec + RP; m_lock = cyc + BL; end
      end
      3'd4: for (int i = 0; i < 4; i++)
              if ((a || i == b) && m_open[i]) begin m_open[i] = 0; m_rp[i] = cyc + RP; end
      3'd5: m_last_ref = cyc;
      3'd6: m_mrs = cyc + MRD;
      3'd7: if (cyc < m_bend && !m_bap) begin m_dat[m_bbank] = cyc + 1; m_bend = cyc; end
      default: ;
    endcase
  endtask

  task automatic step(input logic [2:0] c, input int b, input bit a, input int exp_acc, input string tg);
    bit e_leg, e_acc;
    logic [3:0] e_open, e_due;
    @(negedge clk);
    req_cmd = c; req_bank = 2'(b); req_a10 = a;
    #1;
    e_leg = m_legal(c, b, a);
    e_acc = e_leg && (c != 3'd0);
    for (int i = 0; i < 4; i++) begin
      e_open[i] = m_open[i];
      e_due[i] = m_open[i] && (cyc - m_act[i] >= LIMIT);
    end
    chk(accept === e_acc && refused === !e_leg, tag_of(c), "accept/refused",
        {accept, refused}, {e_acc, !e_leg});
    chk({cs_n, ras_n, cas_n, we_n, ba, a10} === {(e_acc ? code(c) : 4'b0111),
        (e_acc ? 2'(b) : 2'b00), (e_acc ? a : 1'b0)}, "R1", "pins",
        {cs_n, ras_n, cas_n, we_n, ba, a10},
        {(e_acc ? code(c) : 4'b0111), (e_acc ? 2'(b) : 2'b00), (e_acc ? a : 1'b0)});
    chk(bank_open === e_open, "R5", "bank_open", bank_open, e_open);
    chk(close_due === e_due, "R10", "close_due", close_due, e_due);
    if (exp_acc >= 0) chk(accept === exp_acc[0], tg, "directed accept", accept, exp_acc);
    if (e_acc) m_apply(c, b, a);
    cyc++;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(3'd0, 0, 0, -1, "");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R11 watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      m_open[i] = 0; m_act[i] = -1000; m_rp[i] = -1000; m_dat[i] = -1000;
    end
    repeat (3) @(negedge clk);
    #1;
    chk(accept === 1'b0 && refused === 1'b0, "R11", "reset accept/refused", {accept, refused}, 0);
    chk({cs_n, ras_n, cas_n, we_n} === 4'b0111, "R11", "reset pins", {cs_n, ras_n, cas_n, we_n}, 7);
    chk(bank_open === 4'b0 && close_due === 4'b0, "R11", "reset banks", bank_open, 0);
    @(negedge clk);
    rst_n = 1'b1;

    step(3'd1, 0, 0, 1, "R11");                                   // c0
    chk({cs_n, ras_n, cas_n, we_n} === 4'b0011, "R1", "act code", {cs_n, ras_n, cas_n, we_n}, 3);
    step(3'd1, 1, 0, 0, "R3");                                    // c1 tRRD
    chk(refused === 1'b1 && {cs_n, ras_n, cas_n, we_n} === 4'b0111, "R2", "refused nop", {refused, cs_n, ras_n, cas_n, we_n}, 5'b10111);
    step(3'd1, 1, 0, 1, "R3");                                    // c2
    step(3'd3, 1, 0, 0, "R4");                                    // c3 tRCD
    step(3'd2, 0, 0, 1, "R4");                                    // c4
    chk({cs_n, ras_n, cas_n, we_n} === 4'b0101, "R1", "read code", {cs_n, ras_n, cas_n, we_n}, 5);
    step(3'd3, 1, 0, 1, "R4");                                    // c5 back to back
    chk({cs_n, ras_n, cas_n, we_n, ba} === 6'b010001, "R1", "write code", {cs_n, ras_n, cas_n, we_n, ba}, 6'b010001);
    step(3'd0, 0, 0, -1, "");                                     // c6
    step(3'd4, 0, 0, 0, "R5");                                    // c7 read recovery
    step(3'd4, 0, 0, 1, "R5");                                    // c8
    step(3'd4, 1, 0, 0, "R5");                                    // c9 write recovery
    step(3'd4, 1, 0, 1, "R5");                                    // c10
    step(3'd5, 0, 0, 0, "R6");                                    // c11 bank1 tRP
    step(3'd0, 0, 0, -1, "");                                     // c12
    step(3'd5, 0, 0, 1, "R6");                                    // c13
    chk({cs_n, ras_n, cas_n, we_n} === 4'b0001, "R1", "refresh code", {cs_n, ras_n, cas_n, we_n}, 1);
    step(3'd1, 2, 0, 0, "R3");                                    // c14 tRC after refresh
    idle(8);                                                      // c15..c22
    step(3'd1, 2, 0, 1, "R3");                                    // c23
    step(3'd4, 2, 0, 0, "R5");                                    // c24 tRAS
    step(3'd6, 0, 0, 0, "R6");                                    // c25 bank open
    idle(4);                                                      // c26..c29
    step(3'd4, 3, 1, 1, "R5");                                    // c30 all banks
    chk({cs_n, ras_n, cas_n, we_n, a10} === 5'b00101, "R1", "precharge-all code", {cs_n, ras_n, cas_n, we_n, a10}, 5);
    step(3'd0, 0, 0, -1, "");                                     // c31
    chk(bank_open === 4'b0, "R5", "all closed", bank_open, 0);
    step(3'd0, 0, 0, -1, "");                                     // c32
    step(3'd6, 0, 0, 1, "R6");                                    // c33
    chk({cs_n, ras_n, cas_n, we_n} === 4'b0000, "R1", "mrs code", {cs_n, ras_n, cas_n, we_n}, 0);
    step(3'd1, 0, 0, 0, "R7");                                    // c34
    step(3'd1, 0, 0, 1, "R7");                                    // c35
    step(3'd0, 0, 0, -1, "");                                     // c36
    step(3'd1, 3, 0, 1, "R3");                                    // c37
    step(3'd3, 0, 1, 1, "R8");                                    // c38 write with AP
    step(3'd0, 0, 0, -1, "");                                     // c39
    chk(bank_open[0] === 1'b0, "R8", "AP closes bank", bank_open[0], 0);
    step(3'd2, 3, 0, 0, "R8");                                    // c40 lockout
    step(3'd7, 0, 0, 0, "R8");                                    // c41 lockout
    step(3'd2, 3, 0, 1, "R8");                                    // c42
    step(3'd7, 0, 0, 1, "R9");                                    // c43
    chk({cs_n, ras_n, cas_n, we_n} === 4'b0110, "R1", "burst stop code", {cs_n, ras_n, cas_n, we_n}, 6);
    step(3'd4, 3, 0, 1, "R9");                                    // c44 shortened recovery
    step(3'd1, 0, 0, 0, "R8");                                    // c45
    step(3'd1, 0, 0, 1, "R8");                                    // c46
    idle(38);                                                     // c47..c84
    step(3'd0, 0, 0, -1, "");                                     // c85
    chk(close_due[0] === 1'b0, "R10", "not yet due", close_due[0], 0);
    step(3'd0, 0, 0, -1, "");                                     // c86
    chk(close_due[0] === 1'b1, "R10", "due", close_due[0], 1);
    step(3'd4, 0, 0, 1, "R10");                                   // c87
    step(3'd0, 0, 0, -1, "");                                     // c88
    chk(close_due === 4'b0, "R10", "due cleared", close_due, 0);

    for (int k = 0; k < 4000; k++) begin
      int r;
      logic [2:0] c;
      r = $urandom_range(99);
      if (r < 28) c = 3'd0;
      else if (r < 45) c = 3'd1;
      else if (r < 55) c = 3'd2;
      else if (r < 65) c = 3'd3;
      else if (r < 80) c = 3'd4;
      else if (r < 86) c = 3'd5;
      else if (r < 90) c = 3'd6;
      else c = 3'd7;
      step(c, $urandom_range(3), ($urandom_range(3) == 0), -1, "");
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule